// File: doc/BRIEF.md
# Thermal Limit Event Generator

This block watches a stream of temperature samples and decides when a thermal alarm pin should be driven. Each time a new sample arrives with its valid strobe, the sample is compared against three programmable limits (high, low and critical). Three status flags are kept, each with hysteresis so that a flag set by a crossing only clears once the temperature has moved back by a selectable margin. Temperatures and limits are signed two's-complement values. The sample has 13 bits at 0.0625 °C per LSB, and the limits have 11 bits at 0.25 °C per LSB.

The flags drive one alarm output in one of three ways. It can follow the flags as a comparator. It can latch high/low events as an interrupt that software releases with a write-one clear. Or it can respond to the critical limit only. The critical condition always acts as a comparator. The output polarity is selectable, an enable bit can mask the alarm entirely, and a shutdown input releases the alarm. The pad is open-drain, so the block presents a single pull-low enable, plus a polarity-free status bit for software.

Top module: `thermal_event_gen`

## Requirements
- R1: Only bits [12:2] of `sampleTemp` (0.25 °C weight, signed) take part in comparisons. Bits [1:0] have no effect on any flag.
- R2: `hystSel` selects the hysteresis: 2'b00 gives 0, 2'b01 gives 6 LSB (1.5 °C), 2'b10 gives 12 LSB (3 °C), 2'b11 gives 24 LSB (6 °C). All arithmetic is signed and does not wrap.
- R3: `flagHigh` sets when the temperature is greater than `limitHigh`. It clears when the temperature is at or below `limitHigh` minus hysteresis. Between those points it holds.
- R4: `flagCrit` sets when the temperature is greater than `limitCrit`. It clears at or below `limitCrit` minus hysteresis. Between those points it holds.
- R5: `flagLow` sets when the temperature is below `limitLow` minus hysteresis. It clears when the temperature is at or above `limitLow`. Between those points it holds.
- R6: After reset all flags are 0, `eventStatus` is 0 and `padPullLow` is 0. Flags change only at a clock edge where `sampleValid` is 1.
- R7: With `intMode`=0 and `critOnly`=0, the event is asserted exactly while any of the three flags is set.
- R8: With `intMode`=1, a 0-to-1 change of `flagHigh` or `flagLow` latches the event. The latch holds until `clearEvent` is 1 at an edge. `clearEvent` has no effect in comparator mode.
- R9: In interrupt mode `flagCrit` asserts the event as a comparator. A clear cannot release the event while `flagCrit` is set.
- R10: With `critOnly`=1, whatever the value of `intMode`, only `flagCrit` asserts the event. The event releases when that flag clears.
- R11: `padPullLow` = 1 means the pad is pulled low. With `eventPolarity`=0 (active-low) the pad is pulled while the event is asserted. With `eventPolarity`=1 (active-high) the pad is pulled while the event is not asserted. With `eventEnable`=0 the pad is never pulled and `eventStatus` is 0.
- R12: While `shutdown` is 1 the event is released and no interrupt is latched. Flags keep tracking samples. After shutdown ends, the interrupt and critical-only modes keep the event released until the next sample. Comparator mode resumes at once.
- R13: `eventStatus` is 1 exactly when the event is asserted and enabled, whatever the value of `eventPolarity`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sampleValid | input | 1 | Strobe: a new sample is present |
| sampleTemp | input | 13 | Signed temperature sample, 0.0625 °C per LSB |
| limitHigh | input | 11 | Signed high limit, 0.25 °C per LSB |
| limitLow | input | 11 | Signed low limit, 0.25 °C per LSB |
| limitCrit | input | 11 | Signed critical limit, 0.25 °C per LSB |
| hystSel | input | 2 | Hysteresis select |
| intMode | input | 1 | 1 = interrupt mode, 0 = comparator mode |
| critOnly | input | 1 | 1 = only the critical limit raises the event |
| eventPolarity | input | 1 | 0 = active-low, 1 = active-high |
| eventEnable | input | 1 | 0 masks the event output |
| clearEvent | input | 1 | Write-one pulse that releases a latched interrupt |
| shutdown | input | 1 | Releases the event and blocks new interrupts |
| flagHigh | output | 1 | Above-high status |
| flagLow | output | 1 | Below-low status |
| flagCrit | output | 1 | Above-critical status |
| eventStatus | output | 1 | Event asserted, polarity-free |
| padPullLow | output | 1 | Open-drain pull-down enable for the alarm pad |

## Verification
Sample sequences walk up through each limit and back down through its hysteresis band, one run for each hysteresis code. This separates a flag that holds inside the band from one that clears too early or too late. Samples that differ only in their two fractional bits show whether the truncation is right, and limits at negative-free boundaries separate strict from non-strict comparisons. The same temperature sequence is replayed in comparator, interrupt and critical-only modes, with clears and shutdown interleaved. This tells self-clearing apart from latching, shows the critical override, and shows the hold-off after shutdown. Both polarities and the enable mask are then applied to a known asserted and a known released state.

// File: rtl/thermal_event_pkg.sv
package thermal_event_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic updFlags;   // load flags from the current sample
    logic clrLatch;   // drop the interrupt latch
    logic allowSet;   // a flag rise may set the latch
  } evtStrobe_t;

  // Flag index positions inside the flag vector
  localparam int FLAG_HIGH = 0;
  localparam int FLAG_CRIT = 1;
  localparam int FLAG_LOW  = 2;
  localparam int NUM_FLAGS = 3;

  localparam int HYST_W = 5;

  // Hysteresis code to LSB count at 0.25 degC
  function automatic logic [HYST_W-1:0] hystSteps(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd0;
      2'b01:   return 5'd6;
      2'b10:   return 5'd12;
      default: return 5'd24;
    endcase
  endfunction

endpackage

// File: rtl/thermal_thresh_flag.sv
module thermal_thresh_flag #(
  parameter int EXT_W = 13,
  parameter bit ABOVE = 1'b1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    update,
  input  logic signed [EXT_W-1:0] tempExt,
  input  logic signed [EXT_W-1:0] limExt,
  input  logic signed [EXT_W-1:0] hystExt,
  output logic                    flag,
  output logic                    rise
);

  logic signed [EXT_W-1:0] bandEdge;
  logic setCond;
  logic clrCond;
  logic flagNext;

  assign bandEdge = limExt - hystExt;

  generate
    if (ABOVE) begin : gAbove
      assign setCond = tempExt > limExt;
      assign clrCond = tempExt <= bandEdge;
    end else begin : gBelow
      assign setCond = tempExt < bandEdge;
      assign clrCond = tempExt >= limExt;
    end
  endgenerate

  always_comb begin
    if (setCond)      flagNext = 1'b1;
    else if (clrCond) flagNext = 1'b0;
    else              flagNext = flag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       flag <= 1'b0;
    else if (update) flag <= flagNext;
  end

  assign rise = update & flagNext & ~flag;

  // R3 / R4 / R5: a flag only rises after its set condition held
  assert_set_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag) |-> $past(setCond));
  // R3 / R4 / R5: a flag only falls after its clear condition held
  assert_clear_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> $past(clrCond));
  assert_hold_no_sample_R6: assert property (@(posedge clk) disable iff (!rstN)
    !update |=> $stable(flag));

endmodule

// File: rtl/thermal_event_dp.sv
module thermal_event_dp
  import thermal_event_pkg::*;
#(
  parameter int SAMPLE_W  = 13,
  parameter int FRAC_DROP = 2,
  parameter int LIMIT_W   = 11
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  evtStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0]  sampleTemp,
  input  logic [LIMIT_W-1:0]   limitHigh,
  input  logic [LIMIT_W-1:0]   limitLow,
  input  logic [LIMIT_W-1:0]   limitCrit,
  input  logic [1:0]           hystSel,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 intLatch
);

  localparam int TEMP_W = SAMPLE_W - FRAC_DROP;
  localparam int EXT_W  = LIMIT_W + 2;

  logic signed [EXT_W-1:0] tempExt;
  logic signed [EXT_W-1:0] hystExt;
  logic [NUM_FLAGS-1:0][LIMIT_W-1:0] limArr;
  logic [NUM_FLAGS-1:0] rises;
  logic anyRise;

  assign tempExt = {{(EXT_W-TEMP_W){sampleTemp[SAMPLE_W-1]}},
                    sampleTemp[SAMPLE_W-1:FRAC_DROP]};
  assign hystExt = {{(EXT_W-HYST_W){1'b0}}, hystSteps(hystSel)};

  assign limArr[FLAG_HIGH] = limitHigh;
  assign limArr[FLAG_CRIT] = limitCrit;
  assign limArr[FLAG_LOW]  = limitLow;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : gFlag
    logic signed [EXT_W-1:0] limExt;
    assign limExt = {{(EXT_W-LIMIT_W){limArr[g][LIMIT_W-1]}}, limArr[g]};
    thermal_thresh_flag #(
      .EXT_W(EXT_W),
      .ABOVE(g != FLAG_LOW)
    ) uFlag (
      .clk     (clk),
      .rstN    (rstN),
      .update  (strobe.updFlags),
      .tempExt (tempExt),
      .limExt  (limExt),
      .hystExt (hystExt),
      .flag    (flags[g]),
      .rise    (rises[g])
    );
  end

  // Only high and low crossings feed the interrupt latch
  assign anyRise = rises[FLAG_HIGH] | rises[FLAG_LOW];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) intLatch <= 1'b0;
    else       intLatch <= (intLatch & ~strobe.clrLatch) | (strobe.allowSet & anyRise);
  end

  assert_latch_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intLatch) |-> $past(strobe.allowSet && strobe.updFlags));
  assert_latch_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrLatch && !strobe.allowSet) |=> !intLatch);

endmodule

// File: rtl/thermal_event_ctl.sv
module thermal_event_ctl
  import thermal_event_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sampleValid,
  input  logic                 intMode,
  input  logic                 critOnly,
  input  logic                 eventPolarity,
  input  logic                 eventEnable,
  input  logic                 clearEvent,
  input  logic                 shutdown,
  input  logic [NUM_FLAGS-1:0] flags,
  input  logic                 intLatch,
  output evtStrobe_t           strobe,
  output logic                 eventStatus,
  output logic                 padPullLow
);

  logic holdOff;
  logic eventActive;
  logic latchMode;

  assign latchMode = intMode & ~critOnly;

  always_comb begin
    strobe.updFlags = sampleValid;
    strobe.allowSet = latchMode & ~shutdown;
    strobe.clrLatch = clearEvent | ~latchMode | shutdown;
  end

  // Hold-off: set by shutdown, released by the first sample afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdOff <= 1'b0;
    else if (shutdown)    holdOff <= 1'b1;
    else if (sampleValid) holdOff <= 1'b0;
  end

  always_comb begin
    if (shutdown)
      eventActive = 1'b0;
    else if (critOnly)
      eventActive = flags[FLAG_CRIT] & ~holdOff;
    else if (intMode)
      eventActive = (intLatch | flags[FLAG_CRIT]) & ~holdOff;
    else
      eventActive = |flags;
  end

  assign eventStatus = eventActive & eventEnable;
  assign padPullLow  = eventEnable & (eventActive ^ eventPolarity);

  assert_resume_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    ((intMode || critOnly) && $past(shutdown)) |-> !eventStatus);
  assert_active_high_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    (eventStatus && eventPolarity) |-> !padPullLow);
  assert_crit_overrides_R9: assert property (@(posedge clk) disable iff (!rstN)
    (intMode && !shutdown && !holdOff && eventEnable && flags[FLAG_CRIT]) |-> eventStatus);

endmodule

// File: rtl/thermal_event_gen.sv
module thermal_event_gen
  import thermal_event_pkg::*;
#(
  parameter int SAMPLE_W  = 13,
  parameter int FRAC_DROP = 2,
  parameter int LIMIT_W   = 11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleTemp,
  input  logic [LIMIT_W-1:0]  limitHigh,
  input  logic [LIMIT_W-1:0]  limitLow,
  input  logic [LIMIT_W-1:0]  limitCrit,
  input  logic [1:0]          hystSel,
  input  logic                intMode,
  input  logic                critOnly,
  input  logic                eventPolarity,
  input  logic                eventEnable,
  input  logic                clearEvent,
  input  logic                shutdown,
  output logic                flagHigh,
  output logic                flagLow,
  output logic                flagCrit,
  output logic                eventStatus,
  output logic                padPullLow
);

  evtStrobe_t           strobe;
  logic [NUM_FLAGS-1:0] flags;
  logic                 intLatch;

  thermal_event_dp #(
    .SAMPLE_W  (SAMPLE_W),
    .FRAC_DROP (FRAC_DROP),
    .LIMIT_W   (LIMIT_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleTemp (sampleTemp),
    .limitHigh  (limitHigh),
    .limitLow   (limitLow),
    .limitCrit  (limitCrit),
    .hystSel    (hystSel),
    .flags      (flags),
    .intLatch   (intLatch)
  );

  thermal_event_ctl uCtl (
    .clk           (clk),
    .rstN          (rstN),
    .sampleValid   (sampleValid),
    .intMode       (intMode),
    .critOnly      (critOnly),
    .eventPolarity (eventPolarity),
    .eventEnable   (eventEnable),
    .clearEvent    (clearEvent),
    .shutdown      (shutdown),
    .flags         (flags),
    .intLatch      (intLatch),
    .strobe        (strobe),
    .eventStatus   (eventStatus),
    .padPullLow    (padPullLow)
  );

  assign flagHigh = flags[FLAG_HIGH];
  assign flagLow  = flags[FLAG_LOW];
  assign flagCrit = flags[FLAG_CRIT];

endmodule

// File: tb/thermal_event_gen_test.sv
module thermal_event_gen_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleValid = 1'b0;
  logic [12:0] sampleTemp = '0;
  logic [10:0] limitHigh = 11'd320;
  logic [10:0] limitLow  = 11'd40;
  logic [10:0] limitCrit = 11'd400;
  logic [1:0]  hystSel = 2'b00;
  logic intMode = 1'b0, critOnly = 1'b0, eventPolarity = 1'b0;
  logic eventEnable = 1'b1, clearEvent = 1'b0, shutdown = 1'b0;
  logic flagHigh, flagLow, flagCrit, eventStatus, padPullLow;

  always #2 clk = ~clk;

  thermal_event_gen uut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleTemp(sampleTemp),
    .limitHigh(limitHigh), .limitLow(limitLow), .limitCrit(limitCrit),
    .hystSel(hystSel), .intMode(intMode), .critOnly(critOnly),
    .eventPolarity(eventPolarity), .eventEnable(eventEnable),
    .clearEvent(clearEvent), .shutdown(shutdown),
    .flagHigh(flagHigh), .flagLow(flagLow), .flagCrit(flagCrit),
    .eventStatus(eventStatus), .padPullLow(padPullLow)
  );

  typedef struct {
    logic [4:0] exp;   // {hi, lo, cr, status, pad}
    string      req;
  } item_t;

  item_t expQ[$];
  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // Expected-state model built from the requirements
  bit mHi, mLo, mCr, mLatch, mHold;

  function automatic int sgn11(input logic [10:0] v);
    return int'($signed(v));
  endfunction

  task automatic step(input string req);
    int t, h, hi, lo, cr;
    bit nHi, nLo, nCr, rise, act;
    h  = (hystSel == 2'b00) ? 0 : (hystSel == 2'b01) ? 6 : (hystSel == 2'b10) ? 12 : 24;
    t  = sgn11(sampleTemp[12:2]);
    hi = sgn11(limitHigh); lo = sgn11(limitLow); cr = sgn11(limitCrit);
    nHi = mHi; nLo = mLo; nCr = mCr;
    if (sampleValid) begin
      nHi = (t > hi) ? 1'b1 : (t <= hi - h) ? 1'b0 : mHi;
      nCr = (t > cr) ? 1'b1 : (t <= cr - h) ? 1'b0 : mCr;
      nLo = (t < lo - h) ? 1'b1 : (t >= lo) ? 1'b0 : mLo;
    end
    rise = (nHi & ~mHi) | (nLo & ~mLo);
    if (intMode && !critOnly && !shutdown) mLatch = (mLatch & ~clearEvent) | rise;
    else mLatch = 1'b0;
    if (shutdown) mHold = 1'b1;
    else if (sampleValid) mHold = 1'b0;
    mHi = nHi; mLo = nLo; mCr = nCr;
    if (shutdown) act = 1'b0;
    else if (critOnly) act = mCr & ~mHold;
    else if (intMode) act = (mLatch | mCr) & ~mHold;
    else act = mHi | mLo | mCr;
    expQ.push_back('{exp: {mHi, mLo, mCr, act & eventEnable,
                           eventEnable & (act ^ eventPolarity)}, req: req});
    @(negedge clk);
  endtask

  task automatic samp(input int q, input int frac, input string req);
    sampleValid = 1'b1;
    sampleTemp  = {q[10:0], frac[1:0]};
    step(req);
    sampleValid = 1'b0;
  endtask

  task automatic clr(input string req);
    clearEvent = 1'b1;
    step(req);
    clearEvent = 1'b0;
  endtask

  // Monitor: compares DUT outputs one ns after each edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (expQ.size() > 0) begin
        item_t it;
        logic [4:0] act;
        it  = expQ.pop_front();
        act = {flagHigh, flagLow, flagCrit, eventStatus, padPullLow};
        compared++;
        if (act !== it.exp) begin
          mismatched++;
          $display("FAIL %s: {hi,lo,cr,status,pad} actual=%b expected=%b at %0t",
                   it.req, act, it.exp, $time);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    step("R6");                          // reset state
    // Comparator mode, no hysteresis
    samp(321, 0, "R3"); samp(320, 3, "R1"); samp(321, 0, "R7");
    samp(300, 0, "R7");
    // Hysteresis codes on the high limit
    hystSel = 2'b01; samp(321, 0, "R2"); samp(316, 0, "R2"); samp(315, 3, "R2"); samp(314, 0, "R2");
    hystSel = 2'b10; samp(321, 0, "R2"); samp(309, 0, "R2"); samp(308, 0, "R2");
    hystSel = 2'b11; samp(321, 0, "R2"); samp(297, 0, "R2"); samp(296, 0, "R2");
    // Low limit
    hystSel = 2'b00; samp(39, 0, "R5"); samp(40, 0, "R5");
    hystSel = 2'b01; samp(34, 0, "R5"); samp(33, 0, "R5"); samp(39, 0, "R5"); samp(40, 0, "R5");
    // Negative temperature well below low limit
    samp(-20, 1, "R5"); samp(100, 0, "R5");
    // Critical limit
    hystSel = 2'b00; samp(401, 0, "R4"); samp(400, 0, "R4"); samp(300, 0, "R4");
    // No update without the strobe
    sampleTemp = {11'd500, 2'b00}; step("R6"); step("R6");
    // Clear ignored in comparator mode
    samp(321, 0, "R8"); clr("R8"); samp(300, 0, "R8");
    // Interrupt mode
    intMode = 1'b1; samp(321, 0, "R8"); samp(300, 0, "R8"); step("R8"); clr("R8"); step("R8");
    samp(10, 0, "R8"); samp(100, 0, "R8"); clr("R8");
    // Critical in interrupt mode
    samp(401, 0, "R9"); clr("R9"); step("R9"); samp(300, 0, "R9");
    // Critical-only
    critOnly = 1'b1; samp(321, 0, "R10"); samp(401, 0, "R10"); samp(399, 0, "R10");
    hystSel = 2'b01; samp(401, 0, "R10"); samp(396, 0, "R10"); samp(394, 0, "R10");
    critOnly = 1'b0; intMode = 1'b0; hystSel = 2'b00; samp(300, 0, "R10");
    // Polarity and enable
    samp(321, 0, "R11"); eventPolarity = 1'b1; step("R13"); samp(300, 0, "R11");
    eventEnable = 1'b0; step("R11"); samp(321, 0, "R11");
    eventPolarity = 1'b0; step("R13"); eventEnable = 1'b1; step("R11");
    // Shutdown in comparator mode
    shutdown = 1'b1; step("R12"); samp(300, 0, "R12"); samp(321, 0, "R12");
    shutdown = 1'b0; step("R12");
    // Shutdown in interrupt mode
    intMode = 1'b1; samp(300, 0, "R12"); samp(401, 0, "R12"); clr("R12");
    shutdown = 1'b1; step("R12"); shutdown = 1'b0; step("R12"); step("R12");
    samp(401, 0, "R12"); samp(300, 0, "R12");
    shutdown = 1'b1; samp(321, 0, "R12"); shutdown = 1'b0; samp(321, 0, "R12");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule